// File: doc/BRIEF.md
# Memory-Mapped Multiply-Accumulate Unit

This block is a word-wide arithmetic peripheral on a simple register bus. Software writes the first operand to one of four offsets. The offset chosen sets the operation: unsigned product, signed product, unsigned accumulate or signed accumulate. Writing the second operand starts the operation with the most recently chosen mode. The double-width result is written in that same clock edge into a low result word and a high result word. A third word, the extension word, holds sign or carry information. The result can therefore be read in the first bus cycle after the second operand is written.

Any operand write can be flagged as a byte write, in which case only the low byte of the write data is used. Mixed sizes (16x16, 16x8, 8x16, 8x8) need no extra setup. Software can preload both result words to seed an accumulation. Successive accumulate operations chain on whatever the result words hold.

Top module: `mmio_mac`

## Requirements
- R1: After reset the operand, result and extension registers all read 0, and the latched mode is unsigned multiply.
- R2: A write to offset 0, 1, 2 or 3 stores operand 1 and latches the mode: 0 unsigned multiply, 1 signed multiply, 2 unsigned accumulate, 3 signed accumulate. A read of any of offsets 0 to 3 returns the stored operand 1.
- R3: A write to offset 4 stores operand 2 and performs the operation in the latched mode, so the result reads back in the next cycle. Operand-2 writes do not change the mode, so several of them in a row reuse the same mode.
- R4: In unsigned multiply, the result words hold the 32-bit unsigned product (low word at offset 5, high word at offset 6) and the extension word (offset 7) reads 0.
- R5: In signed multiply, the result words hold the two's-complement product, and the extension word is FFFFh when that product is negative and 0 otherwise.
- R6: In unsigned accumulate, the unsigned product is added to the 32-bit value {high, low}. The result words take the low 32 bits of the sum and the extension word takes its carry out (0 or 1).
- R7: In signed accumulate, the signed product is added to {high, low} with 32-bit wraparound, and the extension word is FFFFh when the new bit 31 is set and 0 otherwise.
- R8: A byte write (wr_byte=1) uses wdata[7:0] only. That byte is zero-extended in unsigned modes and sign-extended in signed modes. Operand 1 is extended according to the mode its offset selects; operand 2 is extended according to the mode already latched.
- R9: Writes to offsets 5 and 6 preload the low and high result words. A byte preload zero-extends the byte. A preload leaves the extension word unchanged.
- R10: The extension word at offset 7 is read-only, and a write to it changes nothing.
- R11: The result and extension words change only on an operand-2 write or a preload. Writing operand 1 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the offset on addr |
| wr_byte | input | 1 | Write carries a byte in wdata[7:0] |
| addr | input | 3 | Register offset for both read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data of the register at addr |

## Verification
A wrong latched mode or a wrongly extended operand is not visible on its own. It shows up as a wrong product or extension word on the read in the very next cycle after the operand-2 write. A wrong accumulator value stays hidden until the next accumulate folds it in, so the stimulus chains accumulations without a preload between them. A corrupted carry or sign flag shows only in the extension word. Every operation is therefore followed by a read of all three result offsets.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_UMUL = 2'd0,
    MODE_SMUL = 2'd1,
    MODE_UACC = 2'd2,
    MODE_SACC = 2'd3
  } mac_mode_e;

  localparam logic [ADDR_W-1:0] OFS_OP2 = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_RLO = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_RHI = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_EXT = 3'd7;

  function automatic logic mode_is_signed(input mac_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_is_accum(input mac_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/mac_operand_reg.sv
module mac_operand_reg
  import mac_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op1_we,
  input  logic          op2_we,
  input  logic          wr_byte,
  input  mac_mode_e     op1_mode,
  input  logic [DW-1:0] wdata,
  output mac_mode_e     mode_q,
  output logic [DW-1:0] op1_q,
  output logic [DW-1:0] op2_q,
  output logic [DW-1:0] op2_next
);
  localparam int PADW = DW - BW;

  function automatic logic [DW-1:0] widen(input logic [DW-1:0] d,
                                          input logic is_byte,
                                          input logic sgn);
    logic [DW-1:0] r;
    if (!is_byte)  r = d;
    else if (sgn)  r = {{PADW{d[BW-1]}}, d[BW-1:0]};
    else           r = {{PADW{1'b0}}, d[BW-1:0]};
    return r;
  endfunction

  logic [DW-1:0] op1_next;

  assign op1_next = widen(wdata, wr_byte, mode_is_signed(op1_mode));
  assign op2_next = widen(wdata, wr_byte, mode_is_signed(mode_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_UMUL;
      op1_q  <= '0;
      op2_q  <= '0;
    end else begin
      if (op1_we) begin
        mode_q <= op1_mode;
        op1_q  <= op1_next;
      end
      if (op2_we) op2_q <= op2_next;
    end
  end
endmodule

// File: rtl/mac_arith.sv
module mac_arith
  import mac_pkg::*;
#(
  parameter int DW = 16
) (
  input  mac_mode_e     mode,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] acc_lo,
  input  logic [DW-1:0] acc_hi,
  output logic [DW-1:0] new_lo,
  output logic [DW-1:0] new_hi,
  output logic [DW-1:0] new_ext
);
  localparam int PW = 2 * DW;

  function automatic logic [PW-1:0] stretch(input logic [DW-1:0] v, input logic sgn);
    return sgn ? {{DW{v[DW-1]}}, v} : {{DW{1'b0}}, v};
  endfunction

  function automatic logic [PW:0] combine(input logic [PW-1:0] prod,
                                          input logic [PW-1:0] acc,
                                          input logic do_acc);
    return do_acc ? ({1'b0, acc} + {1'b0, prod}) : {1'b0, prod};
  endfunction

  logic [PW-1:0] prod;
  logic [PW:0]   sum;
  logic          sgn;

  assign sgn  = mode_is_signed(mode);
  assign prod = stretch(opa, sgn) * stretch(opb, sgn);
  assign sum  = combine(prod, {acc_hi, acc_lo}, mode_is_accum(mode));

  assign new_lo = sum[DW-1:0];
  assign new_hi = sum[PW-1:DW];

  always_comb begin
    if (sgn)                      new_ext = {DW{sum[PW-1]}};
    else if (mode_is_accum(mode)) new_ext = {{(DW-1){1'b0}}, sum[PW]};
    else                          new_ext = '0;
  end
endmodule

// File: rtl/mac_result_reg.sv
module mac_result_reg #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_op,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic          wr_byte,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] new_lo,
  input  logic [DW-1:0] new_hi,
  input  logic [DW-1:0] new_ext,
  output logic [DW-1:0] res_lo,
  output logic [DW-1:0] res_hi,
  output logic [DW-1:0] res_ext
);
  logic [DW-1:0] preload_val;

  assign preload_val = wr_byte ? {{(DW-BW){1'b0}}, wdata[BW-1:0]} : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_lo  <= '0;
      res_hi  <= '0;
      res_ext <= '0;
    end else if (load_op) begin
      res_lo  <= new_lo;
      res_hi  <= new_hi;
      res_ext <= new_ext;
    end else begin
      if (lo_we) res_lo <= preload_val;
      if (hi_we) res_hi <= preload_val;
    end
  end
endmodule

// File: rtl/mmio_mac.sv
module mmio_mac
  import mac_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  logic          op1_fire, op2_fire, lo_fire, hi_fire, ext_wr_try, pre_fire;
  mac_mode_e     mode_q;
  logic [DW-1:0] op1_q, op2_q, op2_next;
  logic [DW-1:0] new_lo, new_hi, new_ext;
  logic [DW-1:0] res_lo, res_hi, res_ext;

  assign op1_fire   = wr_en && !addr[ADDR_W-1];
  assign op2_fire   = wr_en && (addr == OFS_OP2);
  assign lo_fire    = wr_en && (addr == OFS_RLO);
  assign hi_fire    = wr_en && (addr == OFS_RHI);
  assign ext_wr_try = wr_en && (addr == OFS_EXT);
  assign pre_fire   = lo_fire || hi_fire;

  mac_operand_reg #(.DW(DW), .BW(BW)) u_ops (
    .clk      (clk),
    .rst_n    (rst_n),
    .op1_we   (op1_fire),
    .op2_we   (op2_fire),
    .wr_byte  (wr_byte),
    .op1_mode (mac_mode_e'(addr[1:0])),
    .wdata    (wdata),
    .mode_q   (mode_q),
    .op1_q    (op1_q),
    .op2_q    (op2_q),
    .op2_next (op2_next)
  );

  mac_arith #(.DW(DW)) u_arith (
    .mode    (mode_q),
    .opa     (op1_q),
    .opb     (op2_next),
    .acc_lo  (res_lo),
    .acc_hi  (res_hi),
    .new_lo  (new_lo),
    .new_hi  (new_hi),
    .new_ext (new_ext)
  );

  mac_result_reg #(.DW(DW), .BW(BW)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_op (op2_fire),
    .lo_we   (lo_fire),
    .hi_we   (hi_fire),
    .wr_byte (wr_byte),
    .wdata   (wdata),
    .new_lo  (new_lo),
    .new_hi  (new_hi),
    .new_ext (new_ext),
    .res_lo  (res_lo),
    .res_hi  (res_hi),
    .res_ext (res_ext)
  );

  always_comb begin
    if (!addr[ADDR_W-1]) rdata = op1_q;
    else begin
      case (addr)
        OFS_OP2: rdata = op2_q;
        OFS_RLO: rdata = res_lo;
        OFS_RHI: rdata = res_hi;
        default: rdata = res_ext;
      endcase
    end
  end
endmodule

// File: rtl/mmio_mac_chk.sv
module mmio_mac_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    addr,
  input logic          op1_fire,
  input logic          op2_fire,
  input logic          pre_fire,
  input logic          ext_wr_try,
  input logic [1:0]    mode,
  input logic [DW-1:0] res_lo,
  input logic [DW-1:0] res_hi,
  input logic [DW-1:0] res_ext
);
  AST_MODE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    op1_fire |=> mode == $past(addr[1:0])); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    op2_fire |=> $stable(mode)); // R3
  AST_UMUL_EXT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op2_fire && mode == 2'd0) |=> res_ext == '0); // R4
  AST_SMUL_EXT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op2_fire && mode == 2'd1) |=> res_ext == {DW{res_hi[DW-1]}}); // R5
  AST_UACC_CARRY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op2_fire && mode == 2'd2) |=> res_ext[DW-1:1] == '0); // R6
  AST_SACC_EXT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op2_fire && mode == 2'd3) |=> res_ext == {DW{res_hi[DW-1]}}); // R7
  AST_EXT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_try |=> $stable(res_ext)); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op2_fire && !pre_fire) |=> ($stable(res_lo) && $stable(res_hi) && $stable(res_ext))); // R11
  AST_PRELOAD_KEEPS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_fire && !op2_fire) |=> $stable(res_ext)); // R9
  AST_OP1_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    op1_fire |=> $stable(res_lo)); // R11
endmodule

bind mmio_mac mmio_mac_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .op1_fire   (op1_fire),
  .op2_fire   (op2_fire),
  .pre_fire   (pre_fire),
  .ext_wr_try (ext_wr_try),
  .mode       (mode_q),
  .res_lo     (res_lo),
  .res_hi     (res_hi),
  .res_ext    (res_ext)
);

// File: tb/sim_mmio_mac.sv
module sim_mmio_mac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_byte = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [31:0] shadow = 32'd0;

  always #4 clk = ~clk;

  mmio_mac u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
               .addr(addr), .wdata(wdata), .rdata(rdata));

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] a;
    logic        ab;
    logic [15:0] b;
    logic        bb;
    logic        pre;
    logic [31:0] pre_val;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{mode:2'd0, a:16'hFFFF, ab:1'b0, b:16'hFFFF, bb:1'b0, pre:1'b0, pre_val:32'h0},
    '{mode:2'd1, a:16'h8000, ab:1'b0, b:16'h7FFF, bb:1'b0, pre:1'b0, pre_val:32'h0},
    '{mode:2'd1, a:16'hFFFF, ab:1'b0, b:16'hFFFF, bb:1'b0, pre:1'b0, pre_val:32'h0},
    '{mode:2'd2, a:16'h0001, ab:1'b0, b:16'h0001, bb:1'b0, pre:1'b1, pre_val:32'hFFFF_FFFF},
    '{mode:2'd3, a:16'h0003, ab:1'b0, b:16'hFFFE, bb:1'b0, pre:1'b1, pre_val:32'h0},
    '{mode:2'd0, a:16'hAB80, ab:1'b1, b:16'h12FF, bb:1'b1, pre:1'b0, pre_val:32'h0},
    '{mode:2'd1, a:16'h3480, ab:1'b1, b:16'h0002, bb:1'b0, pre:1'b0, pre_val:32'h0},
    '{mode:2'd3, a:16'h00FF, ab:1'b1, b:16'h0005, bb:1'b0, pre:1'b1, pre_val:32'h0000_0010},
    '{mode:2'd2, a:16'h1234, ab:1'b0, b:16'h00F0, bb:1'b1, pre:1'b0, pre_val:32'h0}
  };

  function automatic longint ext_op(input logic [15:0] v, input logic is_byte, input logic sg);
    if (is_byte) return sg ? longint'($signed(v[7:0])) : longint'(v[7:0]);
    return sg ? longint'($signed(v)) : longint'(v);
  endfunction

  // returns {ext, hi, lo}
  function automatic logic [47:0] model(input logic [1:0] m, input logic [15:0] a, input logic ab,
                                        input logic [15:0] b, input logic bb, input logic [31:0] acc);
    longint p, s;
    logic [31:0] r;
    logic [15:0] e;
    p = ext_op(a, ab, m[0]) * ext_op(b, bb, m[0]);
    s = m[1] ? (longint'(acc) + p) : p;
    r = s[31:0];
    if (m == 2'd0)      e = 16'h0;
    else if (m[0])      e = r[31] ? 16'hFFFF : 16'h0;
    else                e = {15'd0, s[32]};
    return {e, r};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic byt);
    @(negedge clk);
    wr_en = 1'b1; wr_byte = byt; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wr_byte = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check_result(input string tag, input logic [47:0] exp);
    logic [15:0] v;
    rd(3'd5, v); chk({tag, " low"}, v, exp[15:0]);
    rd(3'd6, v); chk({tag, " high"}, v, exp[31:16]);
    rd(3'd7, v); chk({tag, " ext"}, v, exp[47:32]);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [47:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v); chk("R1 reset value", v, 16'h0);
    end

    // Vector table: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 9; i++) begin
      if (VEC[i].pre) begin
        wr(3'd5, VEC[i].pre_val[15:0], 1'b0);
        wr(3'd6, VEC[i].pre_val[31:16], 1'b0);
        shadow = VEC[i].pre_val;
      end
      wr({1'b0, VEC[i].mode}, VEC[i].a, VEC[i].ab);
      wr(3'd4, VEC[i].b, VEC[i].bb);
      exp = model(VEC[i].mode, VEC[i].a, VEC[i].ab, VEC[i].b, VEC[i].bb, shadow);
      shadow = exp[31:0];
      case (VEC[i].mode)
        2'd0: check_result("R4 unsigned multiply", exp);
        2'd1: check_result("R5 signed multiply", exp);
        2'd2: check_result("R6 unsigned accumulate", exp);
        default: check_result("R7 signed accumulate", exp);
      endcase
    end

    // R2 R8: operand 1 readback, sign-extended byte, visible at all four offsets
    wr(3'd1, 16'h5A80, 1'b1);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), v); chk("R2 R8 op1 readback", v, 16'hFF80);
    end
    wr(3'd0, 16'h5A80, 1'b1);
    rd(3'd2, v); chk("R8 op1 byte zero-extend", v, 16'h0080);

    // R3: mode persists for consecutive operand-2 writes; R8 op2 extension from latched mode
    wr(3'd1, 16'h0002, 1'b0);
    wr(3'd4, 16'h00FF, 1'b1);
    rd(3'd4, v); chk("R8 op2 sign-extend", v, 16'hFFFF);
    check_result("R3 first op2", 48'hFFFF_FFFF_FFFE);
    wr(3'd4, 16'h0010, 1'b0);
    check_result("R3 repeated op2", 48'h0000_0000_0020);

    // R11: operand-1 write leaves result alone
    wr(3'd3, 16'h7777, 1'b0);
    check_result("R11 op1 write no effect", 48'h0000_0000_0020);

    // R9: byte preload zero-extends, ext unchanged
    wr(3'd0, 16'h0001, 1'b0);
    wr(3'd2, 16'h0001, 1'b0);
    wr(3'd5, 16'hFFFF, 1'b0);
    wr(3'd6, 16'hFFFF, 1'b0);
    wr(3'd4, 16'h0001, 1'b0);
    check_result("R6 carry before preload", 48'h0001_0000_0000);
    wr(3'd5, 16'hC3A5, 1'b1);
    wr(3'd6, 16'h1234, 1'b0);
    check_result("R9 byte preload", 48'h0001_1234_00A5);

    // R10: extension word is read-only
    wr(3'd7, 16'hBEEF, 1'b0);
    rd(3'd7, v); chk("R10 ext write ignored", v, 16'h0001);
    rd(3'd5, v); chk("R10 low unchanged", v, 16'h00A5);

    // R11: idle cycles keep results
    repeat (5) @(negedge clk);
    check_result("R11 idle hold", 48'h0001_1234_00A5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule